// File: doc/BRIEF.md
# Signed-Duty Midpoint-Reload PWM Generator

This block turns an 8-bit signed duty command into a single pulse-width-modulated output bit. A free-running counter steps once per enabled clock and treats its own value as a two's complement number, so each period runs from the most negative count (0x80, -128) up to the most positive (0x7F, +127). The step from 0x7F back to 0x80 is the period boundary.

At that boundary the duty command is captured into a compare register, the output is cleared and a one-cycle period-start strobe is raised. Later in the period the output goes high as soon as the count rises above the captured value, and it then stays high until the next boundary. A command written mid-period therefore has no effect until the next period begins. The number of high counts in a period equals 127 minus the command, which spans 0 to 255 of the 256 counts.

Top module: `pwm_midpoint_gen`

## Requirements
- R1: The duty command `duty_i` is an 8-bit two's complement value; in a period that uses command d, `pwm_o` is high for exactly 127 - d of the 256 counts (for example d = 0 gives 127 high counts, d = -100 gives 227).
- R2: The counter advances by one on each clock with `en` high and wraps continuously, so period-start strobes are exactly 256 enabled clocks apart.
- R3: The command is captured only on the enabled clock where the count steps from 0x7F to 0x80; a change of `duty_i` at any other time does not affect the current period.
- R4: On the clock where the count steps from 0x7F to 0x80, `pwm_o` is driven low.
- R5: `pwm_o` is registered: on an enabled clock that moves the count to value c, `pwm_o` becomes high when c, taken as signed, exceeds the captured value; once high it stays high until the next boundary. In a period that uses command d, the sample at position i (i = 0 at the strobe) is high exactly when i >= 1 and i - 128 > d.
- R6: A command of +127 keeps `pwm_o` low for the whole period; a command of -128 keeps it high for 255 of the 256 counts, low only on the first count.
- R7: `period_start_o` is high for exactly one cycle, the cycle in which the count is 0x80 right after a capture, and low at all other times.
- R8: Synchronous reset sets the count to 0x80, the captured value to +127, and `pwm_o` and `period_start_o` low; so after reset is released with `en` high, `pwm_o` stays low and the first strobe appears after exactly 256 clocks.
- R9: While `en` is low, the count, the captured value and `pwm_o` hold, no capture takes place and `period_start_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the generator |
| duty_i | input | 8 | Signed duty command, two's complement |
| pwm_o | output | 1 | Registered PWM output |
| period_start_o | output | 1 | One-cycle strobe at the first count of each period |

## Verification
The bench drives both extremes of the command range: +127, where a design comparing unsigned or with "greater or equal" would pulse at least once, and -128, where an off-by-one in the compare timing would give 254 or 256 high counts instead of 255. It rewrites the command halfway through a period, which a design loading the compare register continuously would follow at once, and checks each sample against the position-exact expectation so an output that toggles instead of sticking is caught. It also freezes the block with `en` low while presenting a command that would raise the output, exposing a design that keeps counting or reloads while disabled, and counts the clocks from reset to the first strobe to catch a wrong reset count.

// File: rtl/pwm_mid_pkg.sv
package pwm_mid_pkg;

  // Default width of the count and of the duty command.
  localparam int unsigned PWM_W_DEFAULT = 8;

  // Signed "strictly greater" of two equally sized words held in plain vectors.
  function automatic logic sgt8(input logic [PWM_W_DEFAULT-1:0] a,
                                input logic [PWM_W_DEFAULT-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

endpackage

// File: rtl/pwm_mid_counter.sv
module pwm_mid_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  // First count of a period is the most negative value, last the most positive.
  localparam logic [W-1:0] CNT_FIRST = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] CNT_LAST  = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_FIRST;
    end else if (en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign nxt_o  = cnt_q + 1'b1;
  assign wrap_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/pwm_mid_latch.sv
module pwm_mid_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // Reset value is the largest positive command: output stays low.
  localparam logic [W-1:0] CMP_RESET = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q <= CMP_RESET;
    end else if (load) begin
      q_q <= d_i;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/pwm_mid_outstage.sv
module pwm_mid_outstage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wrap_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] cmp_i,
  output logic         pwm_o,
  output logic         start_o
);
  logic pwm_q;
  logic start_q;
  logic above;

  // Signed compare of the count about to be entered against the captured value.
  assign above = $signed(nxt_i) > $signed(cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= en & wrap_i;
      if (en) begin
        if (wrap_i) begin
          pwm_q <= 1'b0;
        end else if (above) begin
          pwm_q <= 1'b1;
        end
      end
    end
  end

  assign pwm_o   = pwm_q;
  assign start_o = start_q;
endmodule

// File: rtl/pwm_midpoint_gen.sv
module pwm_midpoint_gen #(
  parameter int unsigned W = pwm_mid_pkg::PWM_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o,
  output logic         period_start_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         wrap;
  logic [W-1:0] cmp_q;

  pwm_mid_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .cnt_o  (cnt_q),
    .nxt_o  (cnt_nxt),
    .wrap_o (wrap)
  );

  pwm_mid_latch #(.W(W)) u_cmp (
    .clk  (clk),
    .rst  (rst),
    .load (en & wrap),
    .d_i  (duty_i),
    .q_o  (cmp_q)
  );

  pwm_mid_outstage #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wrap_i  (wrap),
    .nxt_i   (cnt_nxt),
    .cmp_i   (cmp_q),
    .pwm_o   (pwm_o),
    .start_o (period_start_o)
  );
endmodule

// File: rtl/pwm_midpoint_chk.sv
module pwm_midpoint_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] duty_i,
  input logic         pwm_o,
  input logic         strobe,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp
);
  localparam logic [W-1:0] CNT_FIRST = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] CNT_LAST  = {1'b0, {(W-1){1'b1}}};

  // R2: each enabled clock advances the count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == $past(cnt) + 1'b1);

  // R3: capture at the boundary takes the command present at that edge
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == CNT_LAST) |=> (cmp == $past(duty_i)));

  // R3: no capture away from the boundary
  p_no_midload_r3: assert property (@(posedge clk) disable iff (rst)
    !(en && cnt == CNT_LAST) |=> $stable(cmp));

  // R4: output is low in the first cycle of a period
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> !pwm_o);

  // R5: output only rises when the count is above the captured value
  p_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> $signed(cnt) > $signed(cmp));

  // R5: once high, stays high until the boundary
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (pwm_o && cnt != CNT_LAST) |=> pwm_o);

  // R7: strobe marks the first count of a period
  p_strobe_pos_r7: assert property (@(posedge clk) disable iff (rst)
    strobe |-> cnt == CNT_FIRST);

  // R9: disabled clocks freeze the state and suppress the strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt) && $stable(pwm_o) && !strobe));
endmodule

bind pwm_midpoint_gen pwm_midpoint_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .duty_i (duty_i),
  .pwm_o  (pwm_o),
  .strobe (period_start_o),
  .cnt    (cnt_q),
  .cmp    (cmp_q)
);

// File: tb/tb_pwm_midpoint_gen.sv
`timescale 1ns/1ps
module tb_pwm_midpoint_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       pwm;
  logic       strobe;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_midpoint_gen dut (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .duty_i         (duty),
    .pwm_o          (pwm),
    .period_start_o (strobe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance until a strobe is sampled; returns the number of ticks taken.
  task automatic sync_period(output int n);
    n = 0;
    do begin
      tick();
      n = n + 1;
    end while (!strobe && n < 600);
  endtask

  // Starting at a strobe sample, check a full period for command d.
  task automatic measure(input int d, input bit mid_change, input logic [7:0] mid_val,
                         input string req);
    int highs = 0;
    int bad = 0;
    int strobes = 0;
    for (int i = 0; i < 256; i++) begin
      bit exp_p;
      exp_p = (i >= 1) && ((i - 128) > d);
      if (pwm !== exp_p) bad = bad + 1;
      if (pwm) highs = highs + 1;
      if (strobe) strobes = strobes + 1;
      if (mid_change && i == 60) duty = mid_val;
      tick();
    end
    check(bad == 0, {req, " R5 per-sample shape"}, bad, 0);
    check(highs == 127 - d, {req, " R1 high count"}, highs, 127 - d);
    check(strobes == 1, "R7 one strobe per period", strobes, 1);
    check(strobe == 1'b1, "R2 next strobe after 256 clocks", strobe, 1);
  endtask

  task automatic t_reset();
    int n;
    int highs = 0;
    rst = 1'b1; en = 1'b0; duty = 8'sd0;
    repeat (3) tick();
    check(pwm == 1'b0 && strobe == 1'b0, "R8 outputs low in reset", {pwm, strobe}, 0);
    rst = 1'b0; en = 1'b1; duty = 8'sd0;
    n = 0;
    do begin
      if (pwm) highs = highs + 1;
      tick();
      n = n + 1;
    end while (!strobe && n < 600);
    check(n == 256, "R8 first strobe 256 clocks after reset", n, 256);
    check(highs == 0, "R8 output low in first period", highs, 0);
  endtask

  task automatic t_duty(input int d, input string req);
    int n;
    duty = d[7:0];
    sync_period(n);
    measure(d, 1'b0, 8'd0, req);
  endtask

  task automatic t_midchange();
    int n;
    duty = 8'sd10;
    sync_period(n);
    // Command changes mid-period: this period still uses +10.
    measure(10, 1'b1, 8'hC0, "R3 mid-period change ignored");
    // The strobe sample now begins the period captured with -64.
    measure(-64, 1'b0, 8'd0, "R3 new command at next period");
  endtask

  task automatic t_enable();
    int n;
    int bad = 0;
    duty = 8'sd127;
    sync_period(n);
    repeat (100) tick();
    check(pwm == 1'b0, "R6 +127 keeps output low", pwm, 0);
    en = 1'b0;
    duty = 8'h80;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (pwm !== 1'b0 || strobe !== 1'b0) bad = bad + 1;
    end
    check(bad == 0, "R9 hold while disabled", bad, 0);
    duty = 8'sd127;
    en = 1'b1;
    n = 0;
    bad = 0;
    do begin
      tick();
      n = n + 1;
      if (pwm) bad = bad + 1;
    end while (!strobe && n < 600);
    check(n == 156, "R9 count resumed where it stopped", n, 156);
    check(bad == 0, "R9 no capture while disabled", bad, 0);
  endtask

  initial begin
    t_reset();
    t_duty(0, "R1 d=0");
    t_duty(-1, "R1 d=-1");
    t_duty(1, "R1 d=1");
    t_duty(64, "R1 d=64");
    t_duty(-100, "R1 d=-100");
    t_duty(127, "R6 d=+127");
    t_duty(-128, "R6 d=-128");
    t_midchange();
    t_enable();
    // R4: after a high period the output is low at the boundary
    duty = 8'h80;
    begin
      int n;
      sync_period(n);
      sync_period(n);
      check(pwm == 1'b0, "R4 output cleared at boundary", pwm, 0);
      tick();
      check(pwm == 1'b1, "R4 output rises after boundary for -128", pwm, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule